// File: doc/BRIEF.md
# Prescaled PWM Channel with Synchronised Configuration

This block produces one pulse-width-modulated output. A byte-wide register port (address, data, write strobe) programs it. The channel picks one of three external clock-enable strobes. It divides the chosen strobe first by a small predivider and then by a power of two. Each divided tick advances a counter that is either 6 or 9 bits wide. The output is high while the counter is below the programmed duty value.

Period, resolution and duty writes go into shadow storage only. They reach the running channel when software issues an explicit sync write. The running channel then adopts them only at the next counter wrap, so a period is never cut short or mixed. The output-enable and source controls act at once. They let software silence the pin without touching the timing setup.

Top module: `pwm_prescale_chan`

## Requirements
- R1: A synchronous reset with `rst_n` low clears every shadow, active and control register and holds `pwm_out` low. After reset the active clock select is 0.
- R2: The register at address 0x41 holds the resolution in bit 4 (0 selects 6-bit, 1 selects 9-bit) and the strobe source in bits 1:0. Value 1 selects `tick_src[0]`, value 2 selects `tick_src[1]` and value 3 selects `tick_src[2]`.
- R3: The register at address 0x42 holds a predivider index in bits 6:5, where 0, 1, 2 and 3 give divide ratios of 1, 3, 5 and 6. Bits 2:0 of the same register hold the exponent e. One PWM period lasts 2^size × 2^e × predivider selected strobes.
- R4: The duty value is 9 bits wide. Bits 7:0 come from address 0x44 and bit 8 comes from bit 0 of address 0x45. In every period the output is high for exactly (duty × 2^e × predivider) strobes.
- R5: In 6-bit mode only duty bits 5:0 take part in the compare.
- R6: The largest duty value gives a level that is never 100%: the output is low while the counter is at 2^size − 1.
- R7: Writes to 0x41, 0x42, 0x44 and 0x45 change nothing at the output until a write of 1 to bit 0 of address 0x47. A write of 0 to that bit has no effect.
- R8: After a sync write, the shadow settings become active at the next counter wrap. If the active clock select is 0, they become active on the following cycle instead. The divider and counter restart from zero at that point.
- R9: The register at address 0x46 acts immediately. Bit 7 enables the output and bit 2 selects the plain PWM source (1 selects PWM). When either bit is 0 the output is low. Bit 1 has no effect.
- R10: An active clock select of 0 freezes the counter at zero, so the output holds the level for count 0.
- R11: The counter runs from 0 to 2^size − 1 and advances once per divided tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| tick_src | input | N_SRC | Clock-enable strobes, selected by clock select 1..N_SRC |
| pwm_out | output | 1 | PWM output |

## Verification
The embedded assertions check on every cycle that the counter never passes its terminal count and moves only on a divided tick or a restart. They also check that the active configuration changes only on a load, that a load leaves the counter at zero, that a terminal count always drives the output low, and that a gated clock produces no ticks. Only the bench's scenarios can show the behaviour seen over whole periods. This covers the high time for each strobe source, predivider, exponent and resolution, the masking of the duty value in 6-bit mode, the shadow writes that stay hidden until sync, and the immediate effect of the enable controls.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CNT_W   = 9;
  localparam int SMALL_W = 6;
  localparam int EXP_W   = 3;
  localparam int EXPC_W  = (1 << EXP_W) - 1;
  localparam int PRE_W   = 3;
  localparam int IDX_W   = 2;

  localparam logic [7:0] A_SIZECLK = 8'h41;
  localparam logic [7:0] A_DIV     = 8'h42;
  localparam logic [7:0] A_DUTY_LO = 8'h44;
  localparam logic [7:0] A_DUTY_HI = 8'h45;
  localparam logic [7:0] A_ENCTL   = 8'h46;
  localparam logic [7:0] A_SYNC    = 8'h47;

  typedef struct packed {
    logic             wide;
    logic [1:0]       csel;
    logic [IDX_W-1:0] pidx;
    logic [EXP_W-1:0] expo;
    logic [CNT_W-1:0] duty;
  } cfg_t;

  function automatic logic [PRE_W-1:0] prediv_of(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd0:    return PRE_W'(1);
      2'd1:    return PRE_W'(3);
      2'd2:    return PRE_W'(5);
      default: return PRE_W'(6);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] top_count(input logic wide);
    return wide ? {CNT_W{1'b1}} : {{(CNT_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};
  endfunction

  function automatic logic [EXPC_W-1:0] exp_limit(input logic [EXP_W-1:0] e);
    return (EXPC_W'(1) << e) - EXPC_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] duty_eff(input logic wide, input logic [CNT_W-1:0] d);
    return wide ? d : {{(CNT_W-SMALL_W){1'b0}}, d[SMALL_W-1:0]};
  endfunction
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       apply_ok,
  output cfg_t       cfg_act,
  output logic       out_en,
  output logic       src_pwm,
  output logic       cfg_load
);
  cfg_t shadow;
  logic pend;
  logic sync_req;
  logic unused_d3;

  assign unused_d3 = wr_data[3];
  assign sync_req  = wr_en && (wr_addr == A_SYNC) && wr_data[0];
  assign cfg_load  = pend && apply_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow  <= '0;
      cfg_act <= '0;
      out_en  <= 1'b0;
      src_pwm <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_SIZECLK: begin
            shadow.wide <= wr_data[4];
            shadow.csel <= wr_data[1:0];
          end
          A_DIV: begin
            shadow.pidx <= wr_data[6:5];
            shadow.expo <= wr_data[2:0];
          end
          A_DUTY_LO: shadow.duty[7:0] <= wr_data;
          A_DUTY_HI: shadow.duty[CNT_W-1] <= wr_data[0];
          A_ENCTL: begin
            out_en  <= wr_data[7];
            src_pwm <= wr_data[2];
          end
          default: ;
        endcase
      end
      if (cfg_load) begin
        cfg_act <= shadow;
        pend    <= 1'b0;
      end
      if (sync_req) pend <= 1'b1;
    end
  end

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg_act));
endmodule

// File: rtl/pwm_divider.sv
module pwm_divider
  import pwm_pkg::*;
#(
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] tick_src,
  input  logic [1:0]       csel,
  input  logic [IDX_W-1:0] pidx,
  input  logic [EXP_W-1:0] expo,
  input  logic             restart,
  output logic             pwm_tick,
  output logic             gated
);
  logic [N_SRC:0]     src_vec;
  logic               strobe;
  logic [PRE_W-1:0]   pre_cnt;
  logic [EXPC_W-1:0]  exp_cnt;
  logic               pre_last;
  logic               exp_last;

  assign src_vec[0] = 1'b0;
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign src_vec[g+1] = tick_src[g];
  end

  assign gated    = (csel == 2'd0);
  assign strobe   = src_vec[csel];
  assign pre_last = (pre_cnt == prediv_of(pidx) - PRE_W'(1));
  assign exp_last = (exp_cnt == exp_limit(expo));
  assign pwm_tick = strobe && pre_last && exp_last;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pre_cnt <= '0;
      exp_cnt <= '0;
    end else if (strobe) begin
      if (pre_last) begin
        pre_cnt <= '0;
        exp_cnt <= exp_last ? '0 : exp_cnt + EXPC_W'(1);
      end else begin
        pre_cnt <= pre_cnt + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_tick,
  input  logic             restart,
  input  logic             wide,
  input  logic [CNT_W-1:0] duty,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             cmp_hi
);
  assign wrap   = pwm_tick && (cnt == top_count(wide));
  assign cmp_hi = (cnt < duty_eff(wide, duty));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (pwm_tick)     cnt <= wrap ? '0 : cnt + CNT_W'(1);
  end

  // R11
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= top_count(wide));

  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_tick && !restart) |=> $stable(cnt));
endmodule

// File: rtl/pwm_prescale_chan.sv
module pwm_prescale_chan
  import pwm_pkg::*;
#(
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  input  logic [N_SRC-1:0] tick_src,
  output logic             pwm_out
);
  cfg_t             cfg_act;
  logic             out_en, src_pwm, cfg_load;
  logic             pwm_tick, gated, wrap, cmp_hi;
  logic [CNT_W-1:0] cnt;

  pwm_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .apply_ok(wrap || gated), .cfg_act(cfg_act),
    .out_en(out_en), .src_pwm(src_pwm), .cfg_load(cfg_load)
  );

  pwm_divider #(.N_SRC(N_SRC)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .csel(cfg_act.csel),
    .pidx(cfg_act.pidx), .expo(cfg_act.expo), .restart(cfg_load),
    .pwm_tick(pwm_tick), .gated(gated)
  );

  pwm_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .restart(cfg_load),
    .wide(cfg_act.wide), .duty(cfg_act.duty), .cnt(cnt), .wrap(wrap),
    .cmp_hi(cmp_hi)
  );

  assign pwm_out = out_en && src_pwm && cmp_hi;

  // R8
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (cnt == '0));

  // R6
  never_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == top_count(cfg_act.wide)) |-> !pwm_out);

  // R10
  gated_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gated |-> !pwm_tick);
endmodule

// File: tb/pwm_prescale_chan_test.sv
`timescale 1ns/1ps
module pwm_prescale_chan_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [2:0] tick_src = '0;
  logic       pwm_out;
  logic [1:0] phase = '0;

  int checks = 0;
  int fails = 0;
  string tag_q[$];
  int    win_q[$];
  int    exp_q[$];

  localparam int SETTLE = 4000;

  pwm_prescale_chan uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tick_src(tick_src), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  // strobes: [2] every cycle, [1] every 2nd, [0] every 4th
  always @(negedge clk) begin
    phase       <= phase + 2'd1;
    tick_src[2] <= 1'b1;
    tick_src[1] <= (phase[0] == 1'b1);
    tick_src[0] <= (phase == 2'd3);
  end

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  // driver side of the scoreboard: queue the expected high count for a window
  task automatic expect_high(input string tag, input int win, input int expv);
    tag_q.push_back(tag);
    win_q.push_back(win);
    exp_q.push_back(expv);
    wait (win_q.size() == 0);
  endtask

  // monitor: count high cycles over one whole period window
  initial begin
    forever begin
      int cnt;
      wait (win_q.size() > 0);
      cnt = 0;
      for (int i = 0; i < win_q[0]; i++) begin
        @(negedge clk);
        if (pwm_out) cnt++;
      end
      check(tag_q[0], cnt, exp_q[0]);
      void'(tag_q.pop_front());
      void'(exp_q.pop_front());
      void'(win_q.pop_front());
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset output", int'(pwm_out), 0);
    rst_n = 1'b1;

    wr(8'h46, 8'h84);
    // R2 R4 R11: 6-bit, fast strobe, /1, e=0, duty 20 -> 20 of 64
    wr(8'h41, 8'h03); wr(8'h42, 8'h00); wr(8'h44, 8'd20); wr(8'h45, 8'h00);
    wr(8'h47, 8'h01); settle();
    expect_high("R4 R11 duty 20 six-bit", 64, 20);

    // R7: shadow write without sync, sync bit written 0
    wr(8'h44, 8'd50); wr(8'h47, 8'h00); settle();
    expect_high("R7 shadow hidden", 64, 20);
    wr(8'h47, 8'h01); settle();
    expect_high("R7 R8 after sync", 64, 50);

    // R5 R6: all ones in 6-bit mode -> bits 5:0 = 63 of 64
    wr(8'h44, 8'hFF); wr(8'h45, 8'h01); wr(8'h47, 8'h01); settle();
    expect_high("R5 R6 six-bit saturation", 64, 63);

    // R4: 9-bit duty 300 split over two registers
    wr(8'h41, 8'h13); wr(8'h44, 8'h2C); wr(8'h45, 8'h01); wr(8'h47, 8'h01); settle();
    expect_high("R4 nine-bit duty 300", 512, 300);
    wr(8'h44, 8'hFF); wr(8'h47, 8'h01); settle();
    expect_high("R6 nine-bit saturation", 512, 511);

    // R3: predivider 3, exponent 2, duty 10 -> period 768, high 120
    wr(8'h41, 8'h03); wr(8'h42, 8'h22); wr(8'h44, 8'd10); wr(8'h45, 8'h00);
    wr(8'h47, 8'h01); settle();
    expect_high("R3 prediv3 exp2", 768, 120);

    // R2 R3: half-rate strobe, predivider 6 -> period 768, high 120
    wr(8'h41, 8'h02); wr(8'h42, 8'h60); wr(8'h47, 8'h01); settle();
    expect_high("R2 R3 mid strobe prediv6", 768, 120);

    // R2 R3: quarter-rate strobe, predivider 5, e=1, duty 32 -> 2560, 1280
    wr(8'h41, 8'h01); wr(8'h42, 8'h41); wr(8'h44, 8'd32); wr(8'h47, 8'h01); settle();
    expect_high("R2 R3 slow strobe prediv5", 2560, 1280);

    // R9: enable controls act immediately
    wr(8'h46, 8'h04); repeat (4) @(negedge clk);
    expect_high("R9 output disabled", 2560, 0);
    wr(8'h46, 8'h80); repeat (4) @(negedge clk);
    expect_high("R9 pattern source", 2560, 0);
    wr(8'h46, 8'h86); repeat (4) @(negedge clk);
    expect_high("R9 ramp bit ignored", 2560, 1280);

    // R10: clock select 0 freezes counter at zero, duty 32 -> always high
    wr(8'h41, 8'h00); wr(8'h47, 8'h01); settle();
    expect_high("R10 gated clock", 64, 64);

    // R1: reset while running
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", int'(pwm_out), 0);
    rst_n = 1'b1;
    expect_high("R1 cleared after reset", 64, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule